// File: doc/BRIEF.md
# Address-Prefixed SPI Chip-Select Expander

This block lets an SPI master that owns a single chip-select line reach up to eight slave devices on a shared data bus. Every transaction opens with one address byte. The expander consumes that byte itself and keeps the device clock idle while it arrives, so no slave ever clocks it in. When the byte ends, the expander asserts the chip select of the addressed slave. From the second byte onward, the master's clock is repeated to the slaves. The master's data line goes to every slave directly.

The master's clock, data and select lines are sampled with a faster system clock, passed through a synchronizer, and then decoded. Address value 8 does not select a slave. It targets a local 8-bit configuration register: the byte after the address is stored there and can be read on a status port. Any address above 8 selects nothing. The master releases its chip select at the end of a transaction, and this returns everything to idle.

Top module: `cse_expander`

## Requirements
- R1: During and directly after reset, every `dev_cs_n` bit is high, `dev_sclk` is low and `cfg_value` is 0x00.
- R2: The first byte of a transaction is taken MSB first on rising `spi_sclk` edges while `spi_cs_n` is low. `dev_sclk` shows no rising edge while this byte is transferred.
- R3: After the address byte, an address A in 0..7 drives `dev_cs_n[A]` low and holds every other bit high. No more than one `dev_cs_n` bit is ever low.
- R4: Once a slave is selected, `dev_sclk` repeats `spi_sclk` starting with the second byte. A slave that samples `spi_mosi` on rising `dev_sclk` edges therefore receives exactly 8 bits per byte, and those bits equal the bytes the master sent.
- R5: An address of 9 or more asserts no chip select, and `dev_sclk` stays low for the rest of the transaction.
- R6: Address 8 asserts no chip select and produces no `dev_sclk` pulse. The byte that follows it, taken MSB first, appears on `cfg_value`. Any later bytes in the same transaction leave `cfg_value` unchanged.
- R7: When `spi_cs_n` goes high, all `dev_cs_n` bits go high and `dev_sclk` goes low. Any address bits received so far are discarded, so the next transaction decodes a fresh address.
- R8: If `spi_cs_n` goes high on the same edge as the eighth rising clock edge of a configuration byte, the release wins and `cfg_value` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples `spi_sclk` |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Master chip select, active low |
| dev_sclk | output | 1 | Gated serial clock to the slaves |
| dev_cs_n | output | 8 | Per-slave chip selects, active low |
| cfg_value | output | 8 | Contents of the configuration register |

## Verification
The edge case that matters is a release of the master chip select in the same system cycle as the last rising edge of the configuration byte. That edge would otherwise commit the write. The bench provokes it by changing `spi_cs_n` and `spi_sclk` on the same system-clock edge. Both signals pass through synchronizers of equal depth, so the decoder sees the two events in a single cycle. The outcome is judged on `cfg_value`: it must keep its earlier value. A full configuration transaction that follows must still write the register normally.

// File: rtl/cse_pkg.sv
package cse_pkg;

    localparam int unsigned CSE_BYTE_W = 8;

    typedef logic [CSE_BYTE_W-1:0] cse_byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_HOLD,
        ST_PASS,
        ST_CFG,
        ST_DONE
    } cse_state_e;

    function automatic cse_state_e cse_classify(cse_byte_t a, int unsigned n_dev);
        if (int'(a) < int'(n_dev))
            return ST_HOLD;
        else if (int'(a) == int'(n_dev))
            return ST_CFG;
        else
            return ST_DONE;
    endfunction

endpackage

// File: rtl/cse_sync.sv
module cse_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cse_frame_ctrl.sv
module cse_frame_ctrl
    import cse_pkg::*;
#(
    parameter int unsigned NUM_DEV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_s,
    input  logic       mosi_s,
    input  logic       cs_n_s,
    output cse_state_e state,
    output cse_byte_t  addr,
    output logic       cfg_we,
    output cse_byte_t  cfg_data
);
    localparam int unsigned CNT_W = $clog2(CSE_BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CSE_BYTE_W - 1);

    logic             sclk_d;
    logic             rise, fall;
    logic [CNT_W-1:0] cnt;
    cse_byte_t        shreg;
    cse_byte_t        shnext;
    logic             last_bit;

    assign rise     = sclk_s & ~sclk_d;
    assign fall     = ~sclk_s & sclk_d;
    assign shnext   = {shreg[CSE_BYTE_W-2:0], mosi_s};
    assign last_bit = (cnt == CNT_LAST);
    assign cfg_data = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            addr   <= '0;
            sclk_d <= 1'b0;
            cfg_we <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            cfg_we <= 1'b0;
            if (cs_n_s) begin
                state <= ST_IDLE;
                cnt   <= '0;
                shreg <= '0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_ADDR: begin
                        state <= ST_ADDR;
                        if (rise) begin
                            shreg <= shnext;
                            if (last_bit) begin
                                cnt   <= '0;
                                addr  <= shnext;
                                state <= cse_classify(shnext, NUM_DEV);
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (fall) state <= ST_PASS;
                    end
                    ST_PASS: begin
                        state <= ST_PASS;
                    end
                    ST_CFG: begin
                        if (rise) begin
                            shreg <= shnext;
                            if (last_bit) begin
                                cnt    <= '0;
                                cfg_we <= 1'b1;
                                state  <= ST_DONE;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: begin
                        state <= ST_DONE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/cse_out_stage.sv
module cse_out_stage
    import cse_pkg::*;
#(
    parameter int unsigned NUM_DEV = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  cse_state_e         state,
    input  cse_byte_t          addr,
    input  logic               sclk_s,
    input  logic               cs_n_s,
    output logic               dev_sclk,
    output logic [NUM_DEV-1:0] dev_cs_n
);
    logic [NUM_DEV-1:0] sel_n;
    logic               selected;

    assign selected = (state == ST_HOLD) || (state == ST_PASS);

    generate
        for (genvar i = 0; i < NUM_DEV; i++) begin : g_dec
            assign sel_n[i] = ~(selected && (addr == CSE_BYTE_W'(i)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_sclk <= 1'b0;
            dev_cs_n <= '1;
        end else begin
            dev_sclk <= ~cs_n_s && (state == ST_PASS) && sclk_s;
            dev_cs_n <= cs_n_s ? '1 : sel_n;
        end
    end
endmodule

// File: rtl/cse_expander.sv
module cse_expander
    import cse_pkg::*;
#(
    parameter int unsigned NUM_DEV     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_sclk,
    input  logic               spi_mosi,
    input  logic               spi_cs_n,
    output logic               dev_sclk,
    output logic [NUM_DEV-1:0] dev_cs_n,
    output logic [7:0]         cfg_value
);
    logic [2:0] raw_in, syn_out;
    logic       sclk_s, mosi_s, cs_n_s;
    cse_state_e state;
    cse_byte_t  addr;
    logic       cfg_we;
    cse_byte_t  cfg_data;
    logic       st_pass;

    assign raw_in = {spi_cs_n, spi_mosi, spi_sclk};

    cse_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_in),
        .q  (syn_out)
    );

    assign sclk_s = syn_out[0];
    assign mosi_s = syn_out[1];
    assign cs_n_s = syn_out[2];

    cse_frame_ctrl #(.NUM_DEV(NUM_DEV)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sclk_s),
        .mosi_s  (mosi_s),
        .cs_n_s  (cs_n_s),
        .state   (state),
        .addr    (addr),
        .cfg_we  (cfg_we),
        .cfg_data(cfg_data)
    );

    cse_out_stage #(.NUM_DEV(NUM_DEV)) u_out (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .addr    (addr),
        .sclk_s  (sclk_s),
        .cs_n_s  (cs_n_s),
        .dev_sclk(dev_sclk),
        .dev_cs_n(dev_cs_n)
    );

    always_ff @(posedge clk) begin
        if (rst)         cfg_value <= '0;
        else if (cfg_we) cfg_value <= cfg_data;
    end

    assign st_pass = (state == ST_PASS);
endmodule

// File: rtl/cse_expander_chk.sv
module cse_expander_chk #(
    parameter int unsigned NUM_DEV = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               cs_n_s,
    input logic               st_pass,
    input logic               cfg_we,
    input logic               dev_sclk,
    input logic [NUM_DEV-1:0] dev_cs_n,
    input logic [7:0]         cfg_value
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (dev_cs_n == '1 && !dev_sclk && cfg_value == 8'h00));

    a_r2_clk_only_in_pass: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_sclk) |-> $past(st_pass));

    a_r3_single_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dev_cs_n));

    a_r5_clk_needs_select: assert property (@(posedge clk) disable iff (rst)
        dev_sclk |-> (dev_cs_n != '1));

    a_r6_cfg_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_value) |-> $past(cfg_we));

    a_r7_release_idles: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (dev_cs_n == '1 && !dev_sclk));
endmodule

bind cse_expander cse_expander_chk #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n_s   (cs_n_s),
    .st_pass  (st_pass),
    .cfg_we   (cfg_we),
    .dev_sclk (dev_sclk),
    .dev_cs_n (dev_cs_n),
    .cfg_value(cfg_value)
);

// File: tb/cse_expander_tb.sv
module cse_expander_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       dev_sclk;
    logic [7:0] dev_cs_n;
    logic [7:0] cfg_value;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    int addr_pulses = 0;
    logic addr_phase = 1'b0;
    logic [31:0] cap = '0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cse_expander u_dut (
        .clk      (clk),
        .rst      (rst),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_cs_n (spi_cs_n),
        .dev_sclk (dev_sclk),
        .dev_cs_n (dev_cs_n),
        .cfg_value(cfg_value)
    );

    // slave model: samples data on rising device clock
    always @(posedge dev_sclk) begin
        pulses = pulses + 1;
        cap    = {cap[30:0], spi_mosi};
        if (addr_phase) addr_pulses = addr_pulses + 1;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(logic [7:0] b, int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            spi_mosi = b[i];
            wclk(HALF);
            spi_sclk = 1'b1;
            wclk(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic open_frame(logic [7:0] a);
        pulses = 0; addr_pulses = 0; cap = '0;
        spi_cs_n = 1'b0;
        wclk(HALF);
        addr_phase = 1'b1;
        spi_bits(a, 8);
        wclk(4);
        addr_phase = 1'b0;
    endtask

    task automatic close_frame();
        wclk(HALF);
        spi_cs_n = 1'b1;
        wclk(6);
    endtask

    task automatic t_reset();
        chk("R1 cs", {24'h0, dev_cs_n}, 32'hFF);
        chk("R1 sclk", {31'h0, dev_sclk}, 32'h0);
        chk("R1 cfg", {24'h0, cfg_value}, 32'h0);
    endtask

    task automatic t_slave(int a, logic [7:0] d0, logic [7:0] d1);
        open_frame(8'(a));
        chk("R2 no clock in address byte", addr_pulses, 0);
        chk("R3 select", {24'h0, dev_cs_n}, {24'h0, ~(8'h01 << a)});
        spi_bits(d0, 8);
        spi_bits(d1, 8);
        chk("R4 pulse count", pulses, 16);
        chk("R4 slave data", cap[15:0], {d0, d1});
        close_frame();
        chk("R7 release cs", {24'h0, dev_cs_n}, 32'hFF);
        chk("R7 release sclk", {31'h0, dev_sclk}, 32'h0);
    endtask

    task automatic t_void(logic [7:0] a);
        open_frame(a);
        chk("R5 no select", {24'h0, dev_cs_n}, 32'hFF);
        spi_bits(8'h96, 8);
        chk("R5 no clock", pulses, 0);
        close_frame();
    endtask

    task automatic t_cfg(logic [7:0] d, logic [7:0] extra);
        open_frame(8'd8);
        chk("R6 no select", {24'h0, dev_cs_n}, 32'hFF);
        spi_bits(d, 8);
        wclk(4);
        chk("R6 cfg written", {24'h0, cfg_value}, {24'h0, d});
        spi_bits(extra, 8);
        wclk(4);
        chk("R6 later byte ignored", {24'h0, cfg_value}, {24'h0, d});
        chk("R6 no clock", pulses, 0);
        close_frame();
    endtask

    task automatic t_partial();
        spi_cs_n = 1'b0;
        wclk(HALF);
        spi_bits(8'hF0, 4);
        close_frame();
        open_frame(8'd2);
        chk("R7 fresh address", {24'h0, dev_cs_n}, 32'hFB);
        close_frame();
    endtask

    task automatic t_collide();
        open_frame(8'd8);
        spi_bits(8'h77, 7);
        spi_mosi = 1'b1;
        wclk(HALF);
        spi_sclk = 1'b1;
        spi_cs_n = 1'b1;
        wclk(HALF);
        spi_sclk = 1'b0;
        wclk(8);
        chk("R8 release beats write", {24'h0, cfg_value}, 32'hA5);
        chk("R8 release cs", {24'h0, dev_cs_n}, 32'hFF);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        wclk(3);
        t_reset();
        rst = 1'b0;
        wclk(3);
        t_reset();
        t_slave(3, 8'h5A, 8'hC3);
        t_slave(0, 8'hFF, 8'h01);
        t_slave(7, 8'h80, 8'h7E);
        t_void(8'd9);
        t_void(8'hFF);
        t_cfg(8'hA5, 8'h3C);
        t_partial();
        t_collide();
        t_cfg(8'h77, 8'h00);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule